// File: doc/BRIEF.md
# Bit-Serial Converter Command Port

This block sits behind a byte-wide host register window and lets software hand-clock serial control words into two external converters. One converter handles playback and the other handles capture. The host opens a frame with a read at one of two addresses: one address selects the playback converter and the other selects the capture converter. After that, every byte the host writes to the data address sends exactly one serial bit, taken from the top bit of the byte. A read at the closing address ends the frame and raises the chip select again.

For each accepted bit the block drives the data pin first. It then produces one serial clock pulse whose low setup phase and high phase each last a parameterised number of system clocks. The block keeps a running count of the bits in the open frame and compares that count with the expected frame length when the frame closes. A playback frame is a 16-bit command, most significant bit first: the upper byte selects the function (for example 0xA6 or 0xA7 for a channel level) and the lower byte carries the value. A capture frame is 32 bits, most significant bit first. From the top byte down it carries the microphone level, the microphone level again, the right line level and the left line level.

The host may issue a write before the previous bit has finished shifting. A single holding slot keeps that write, and a control read that arrives while bits are still in flight is also held until the line is drained. Two sticky flags report misuse: one for protocol violations and one for frames closed at the wrong length.

Top module: `codec_cmd_port`

## Requirements
- R1: After reset both chip selects are high, the serial clock and data are low, busy is low, both error flags are clear and the frame bit count is 0.
- R2: A host read at the playback-open address drives the playback chip select low and clears the frame bit count to 0. The capture chip select stays high.
- R3: A host read at the data address opens a capture frame. The capture chip select goes low and the playback chip select stays high.
- R4: Each host write to the data address during an open frame sends one bit equal to bit 7 of the written byte. Bits 6..0 of the byte have no effect. The write produces exactly one serial clock pulse and increments the frame bit count by one.
- R5: For every bit the data pin takes its value HALF_DIV system clocks before the serial clock rises. The serial clock then stays high for HALF_DIV system clocks, and the data pin does not change while the serial clock is high.
- R6: A playback frame delivers its 16 bits on the serial data pin in the order written, so a command word sent MSB first (upper byte the command, for example 0xA6, lower byte the value) appears MSB first on successive serial clock rising edges.
- R7: A capture frame delivers its 32 bits in the order written, from the top byte down: mic level, mic level, right line level, left line level.
- R8: A host read at the close address raises whichever chip select is low. If bits are still in flight or held, the close takes effect only after they have been shifted out. The chip select does not change while a bit is shifting.
- R9: A write to the data address while no frame is open produces no serial clock pulse and sets the sticky protocol-error flag.
- R10: Busy is high while a bit is held or shifting. A write that arrives while a bit is shifting is held in a one-entry slot and sent afterwards. A write that finds the slot still occupied is dropped and sets the protocol-error flag.
- R11: Closing a playback frame with a count other than 16, or a capture frame with a count other than 32, sets the sticky length-error flag. Correct lengths leave it clear.
- R12: An open request while a frame is already open, or a second control read while one is still held, is ignored and sets the protocol-error flag. The open frame and its chip select are unchanged.
- R13: Reads at any other address, and writes to any address other than the data address, change neither the chip selects nor the serial pins nor the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Host register address |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data; bit 7 is the serial bit |
| cs_play_n | output | 1 | Playback converter chip select, active low |
| cs_cap_n | output | 1 | Capture converter chip select, active low |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| busy | output | 1 | A bit or control request is held or in flight |
| proto_err | output | 1 | Sticky protocol-error flag |
| len_err | output | 1 | Sticky frame-length-error flag |
| frame_bits | output | CNT_W | Bits sent in the current or last frame |

## Verification
The bench sends two writes on consecutive cycles. A design without the holding slot, or one that rejects a write arriving in the same cycle the slot empties, would lose the second bit and show one clock pulse where two are expected. The bench also sends three writes on consecutive cycles, where the third must be dropped. It measures the setup and high phases of a pulse in cycles, which catches an off-by-one divider. It closes a frame with a short count to catch a design that never raises the length error, and it opens a second frame on top of the first to catch one that switches chip selects when it should refuse.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_PLAY = 2'd1,
    FR_CAP  = 2'd2
  } frame_e;

  typedef enum logic [1:0] {
    CT_NONE      = 2'd0,
    CT_OPEN_PLAY = 2'd1,
    CT_OPEN_CAP  = 2'd2,
    CT_CLOSE     = 2'd3
  } ctl_e;

  typedef struct packed {
    logic bit_ev;
    logic bit_val;
    ctl_e ctl;
  } host_ev_t;

endpackage

// File: rtl/host_decode.sv
module host_decode
  import codec_port_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SER_BIT    = 7,
  parameter logic [ADDR_W-1:0] PLAY_ADDR  = 8'h0E,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 8'h0B,
  parameter logic [ADDR_W-1:0] CLOSE_ADDR = 8'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output host_ev_t          ev
);

  // A read and a write in the same cycle: the read is taken.
  always_ff @(posedge clk) begin
    if (rst) begin
      ev <= '0;
    end else begin
      ev.bit_ev  <= 1'b0;
      ev.bit_val <= 1'b0;
      ev.ctl     <= CT_NONE;
      if (bus_rd) begin
        if (bus_addr == PLAY_ADDR)       ev.ctl <= CT_OPEN_PLAY;
        else if (bus_addr == DATA_ADDR)  ev.ctl <= CT_OPEN_CAP;
        else if (bus_addr == CLOSE_ADDR) ev.ctl <= CT_CLOSE;
      end else if (bus_wr && bus_addr == DATA_ADDR) begin
        ev.bit_ev  <= 1'b1;
        ev.bit_val <= bus_wdata[SER_BIT];
      end
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    !(ev.bit_ev && ev.ctl != CT_NONE)); // R13

endmodule

// File: rtl/hold_slot.sv
module hold_slot #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] val
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      val  <= '0;
    end else begin
      if (load) begin
        full <= 1'b1;
        val  <= load_val;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  AST_SLOT_NO_CLOBBER: assert property (@(posedge clk) disable iff (rst)
    (full && !take) |-> !load); // R10

endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic din,
  output logic sclk,
  output logic sdata,
  output logic active
);

  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HW-1:0] LAST = HW'(HALF_DIV - 1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk   <= 1'b0;
      sdata  <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (start) begin
        sdata  <= din;
        active <= 1'b1;
        cnt    <= '0;
      end
    end else if (cnt == LAST) begin
      cnt <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk   <= 1'b0;
        active <= 1'b0;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Phase-length monitors for the timing checks.
  logic [HW:0] lo_run, hi_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      lo_run <= (active && !sclk) ? lo_run + 1'b1 : '0;
      hi_run <= sclk ? hi_run + 1'b1 : '0;
    end
  end

  AST_SETUP_TIME: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> lo_run == (HW+1)'(HALF_DIV)); // R5
  AST_HIGH_TIME: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> hi_run == (HW+1)'(HALF_DIV)); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdata)); // R5

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import codec_port_pkg::*;
#(
  parameter int PLAY_BITS = 16,
  parameter int CAP_BITS  = 32,
  parameter int CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  host_ev_t         ev,
  input  logic             sh_active,
  output logic             sh_start,
  output logic             sh_din,
  output logic             cs_play_n,
  output logic             cs_cap_n,
  output logic             busy,
  output logic             proto_err,
  output logic             len_err,
  output logic [CNT_W-1:0] frame_bits
);

  localparam logic [CNT_W-1:0] PLAY_LEN = CNT_W'(PLAY_BITS);
  localparam logic [CNT_W-1:0] CAP_LEN  = CNT_W'(CAP_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  frame_e frame_q, frame_d;
  ctl_e   kind_q, kind_d, exec_kind;
  logic   ctl_pend_q, ctl_pend_d;
  logic [CNT_W-1:0] cnt_d;
  logic   buf_full, buf_val;
  logic   drained, launch, bit_ok;
  logic   ctl_err, open_err, len_set;

  assign drained = !buf_full && !sh_active && !sh_start;
  assign launch  =  buf_full && !sh_active && !sh_start;
  assign bit_ok  = ev.bit_ev && !ctl_pend_q && (frame_q != FR_IDLE) &&
                   (!buf_full || launch);

  hold_slot #(.W(1)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .load     (bit_ok),
    .load_val (ev.bit_val),
    .take     (launch),
    .full     (buf_full),
    .val      (buf_val)
  );

  // Control requests run only on a drained line; otherwise one is held.
  always_comb begin
    exec_kind  = CT_NONE;
    ctl_pend_d = ctl_pend_q;
    kind_d     = kind_q;
    ctl_err    = 1'b0;
    if (ctl_pend_q) begin
      if (drained) begin
        exec_kind  = kind_q;
        ctl_pend_d = 1'b0;
      end
      if (ev.ctl != CT_NONE) begin
        if (drained) begin
          ctl_pend_d = 1'b1;
          kind_d     = ev.ctl;
        end else begin
          ctl_err = 1'b1;
        end
      end
    end else if (ev.ctl != CT_NONE) begin
      if (drained) begin
        exec_kind = ev.ctl;
      end else begin
        ctl_pend_d = 1'b1;
        kind_d     = ev.ctl;
      end
    end
  end

  always_comb begin
    frame_d  = frame_q;
    cnt_d    = frame_bits;
    open_err = 1'b0;
    len_set  = 1'b0;
    case (exec_kind)
      CT_OPEN_PLAY, CT_OPEN_CAP: begin
        if (frame_q != FR_IDLE) begin
          open_err = 1'b1;
        end else begin
          frame_d = (exec_kind == CT_OPEN_PLAY) ? FR_PLAY : FR_CAP;
          cnt_d   = '0;
        end
      end
      CT_CLOSE: begin
        if (frame_q == FR_PLAY && frame_bits != PLAY_LEN) len_set = 1'b1;
        if (frame_q == FR_CAP  && frame_bits != CAP_LEN)  len_set = 1'b1;
        frame_d = FR_IDLE;
      end
      default: ;
    endcase
    if (launch && frame_bits != CNT_MAX) cnt_d = frame_bits + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q    <= FR_IDLE;
      kind_q     <= CT_NONE;
      ctl_pend_q <= 1'b0;
      frame_bits <= '0;
      cs_play_n  <= 1'b1;
      cs_cap_n   <= 1'b1;
      sh_start   <= 1'b0;
      sh_din     <= 1'b0;
      proto_err  <= 1'b0;
      len_err    <= 1'b0;
    end else begin
      frame_q    <= frame_d;
      kind_q     <= kind_d;
      ctl_pend_q <= ctl_pend_d;
      frame_bits <= cnt_d;
      cs_play_n  <= (frame_d != FR_PLAY);
      cs_cap_n   <= (frame_d != FR_CAP);
      sh_start   <= launch;
      if (launch) sh_din <= buf_val;
      if ((ev.bit_ev && !bit_ok) || ctl_err || open_err) proto_err <= 1'b1;
      if (len_set) len_err <= 1'b1;
    end
  end

  assign busy = buf_full || sh_active || sh_start || ctl_pend_q;

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    cs_play_n || cs_cap_n); // R12
  AST_SHIFT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    sh_active |-> (!cs_play_n || !cs_cap_n)); // R9
  AST_CS_STABLE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    sh_active |=> ($stable(cs_play_n) && $stable(cs_cap_n))); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (sh_start && $past(frame_bits) != CNT_MAX) |-> frame_bits == $past(frame_bits) + 1'b1); // R4
  AST_OPEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_play_n) || $fell(cs_cap_n)) |-> frame_bits == '0); // R2
  AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err); // R9
  AST_LEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    len_err |=> len_err); // R11

endmodule

// File: rtl/codec_cmd_port.sv
module codec_cmd_port
  import codec_port_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int HALF_DIV  = 4,
  parameter int PLAY_BITS = 16,
  parameter int CAP_BITS  = 32,
  parameter logic [ADDR_W-1:0] PLAY_ADDR  = 8'h0E,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 8'h0B,
  parameter logic [ADDR_W-1:0] CLOSE_ADDR = 8'h0A,
  localparam int CNT_W = $clog2(CAP_BITS) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic              cs_play_n,
  output logic              cs_cap_n,
  output logic              sclk,
  output logic              sdata,
  output logic              busy,
  output logic              proto_err,
  output logic              len_err,
  output logic [CNT_W-1:0]  frame_bits
);

  host_ev_t ev;
  logic     sh_start, sh_din, sh_active;

  host_decode #(
    .ADDR_W     (ADDR_W),
    .SER_BIT    (7),
    .PLAY_ADDR  (PLAY_ADDR),
    .DATA_ADDR  (DATA_ADDR),
    .CLOSE_ADDR (CLOSE_ADDR)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .ev        (ev)
  );

  frame_ctrl #(
    .PLAY_BITS (PLAY_BITS),
    .CAP_BITS  (CAP_BITS),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .sh_active  (sh_active),
    .sh_start   (sh_start),
    .sh_din     (sh_din),
    .cs_play_n  (cs_play_n),
    .cs_cap_n   (cs_cap_n),
    .busy       (busy),
    .proto_err  (proto_err),
    .len_err    (len_err),
    .frame_bits (frame_bits)
  );

  serial_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .start  (sh_start),
    .din    (sh_din),
    .sclk   (sclk),
    .sdata  (sdata),
    .active (sh_active)
  );

  AST_PULSE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> (!cs_play_n || !cs_cap_n)); // R9

endmodule

// File: tb/codec_cmd_port_test.sv
`timescale 1ns/1ps
module codec_cmd_port_test;

  localparam int HALF = 3;
  localparam logic [7:0] A_PLAY  = 8'h0E;
  localparam logic [7:0] A_DATA  = 8'h0B;
  localparam logic [7:0] A_CLOSE = 8'h0A;
  localparam logic [7:0] A_OTHER = 8'h0C;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       cs_play_n, cs_cap_n, sclk, sdata, busy, proto_err, len_err;
  logic [6:0] frame_bits;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  codec_cmd_port #(.HALF_DIV(HALF), .PLAY_ADDR(A_PLAY), .DATA_ADDR(A_DATA),
                   .CLOSE_ADDR(A_CLOSE)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .cs_play_n(cs_play_n), .cs_cap_n(cs_cap_n),
    .sclk(sclk), .sdata(sdata), .busy(busy), .proto_err(proto_err),
    .len_err(len_err), .frame_bits(frame_bits));

  logic [63:0] mon_word = '0;
  int          mon_cnt = 0;
  always @(posedge sclk) begin
    mon_word = {mon_word[62:0], sdata};
    mon_cnt  = mon_cnt + 1;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_read(logic [7:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic host_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic send_word(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      host_write(A_DATA, {v[i], 7'(8'h55 ^ i)});
      wait_idle();
    end
  endtask

  task automatic t_reset();
    check("R1 cs_play_n", cs_play_n, 1);
    check("R1 cs_cap_n", cs_cap_n, 1);
    check("R1 pins", {sclk, sdata, busy}, 0);
    check("R1 flags", {proto_err, len_err}, 0);
    check("R1 frame_bits", frame_bits, 0);
  endtask

  task automatic t_play_frame();
    host_read(A_PLAY); wait_idle();
    check("R2 cs", {cs_play_n, cs_cap_n}, 2'b01);
    check("R2 frame_bits", frame_bits, 0);
    send_word(64'hA63C, 16);
    check("R6 word", mon_word[15:0], 16'hA63C);
    check("R4 frame_bits", frame_bits, 16);
    host_read(A_CLOSE); wait_idle();
    check("R8 cs released", {cs_play_n, cs_cap_n}, 2'b11);
    check("R11 no len_err", len_err, 0);
  endtask

  task automatic t_cap_frame();
    logic [31:0] w;
    w = {8'h5A, 8'h5A, 8'h21, 8'h83};
    host_read(A_DATA); wait_idle();
    check("R3 cs", {cs_play_n, cs_cap_n}, 2'b10);
    send_word({32'h0, w}, 32);
    check("R7 word", mon_word[31:0], w);
    check("R7 frame_bits", frame_bits, 32);
    host_read(A_CLOSE); wait_idle();
    check("R8 cs released", {cs_play_n, cs_cap_n}, 2'b11);
    check("R11 no len_err", len_err, 0);
  endtask

  task automatic t_timing();
    int lo, hi, c0;
    logic sd;
    host_read(A_PLAY); wait_idle();
    c0 = mon_cnt;
    host_write(A_DATA, 8'h80);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 data before clock", {sclk, sdata}, 2'b01);
    lo = 1;
    forever begin @(negedge clk); if (sclk) break; lo++; end
    check("R5 setup cycles", lo, HALF);
    hi = 1; sd = sdata;
    forever begin
      @(negedge clk);
      if (!sclk) break;
      hi++;
      if (sdata !== sd) check("R5 data hold", sdata, sd);
    end
    check("R5 high cycles", hi, HALF);
    wait_idle();
    check("R4 one pulse", mon_cnt - c0, 1);
    send_word(64'h0, 15);
    host_read(A_CLOSE); wait_idle();
    check("R11 no len_err", len_err, 0);
  endtask

  task automatic t_buffer();
    int c0;
    host_read(A_PLAY); wait_idle();
    c0 = mon_cnt;
    @(negedge clk); bus_addr = A_DATA; bus_wdata = 8'h80; bus_wr = 1'b1;
    @(negedge clk); bus_wdata = 8'h7F;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
    check("R10 busy", busy, 1);
    wait_idle();
    check("R10 both bits sent", mon_cnt - c0, 2);
    check("R10 bit order", mon_word[1:0], 2'b10);
    check("R10 no error", proto_err, 0);
    send_word(64'h0, 14);
    host_read(A_CLOSE); wait_idle();
    check("R11 no len_err", len_err, 0);
  endtask

  task automatic t_len_and_other();
    int c0;
    host_read(A_DATA); wait_idle();
    send_word(64'h15, 5);
    c0 = mon_cnt;
    host_write(A_OTHER, 8'h80); wait_idle();
    host_read(A_OTHER); wait_idle();
    check("R13 no pulse", mon_cnt - c0, 0);
    check("R13 cs kept", {cs_play_n, cs_cap_n}, 2'b10);
    check("R13 flags", {proto_err, len_err}, 0);
    host_read(A_CLOSE); wait_idle();
    check("R11 len_err short frame", len_err, 1);
    check("R8 cs released", cs_cap_n, 1);
  endtask

  task automatic t_protocol();
    int c0;
    c0 = mon_cnt;
    host_write(A_DATA, 8'h80); wait_idle();
    check("R9 no pulse outside frame", mon_cnt - c0, 0);
    check("R9 proto_err", proto_err, 1);
    host_read(A_PLAY); wait_idle();
    host_read(A_DATA); wait_idle();
    check("R12 second open ignored", {cs_play_n, cs_cap_n}, 2'b01);
    c0 = mon_cnt;
    @(negedge clk); bus_addr = A_DATA; bus_wdata = 8'h80; bus_wr = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b0;
    wait_idle();
    check("R10 overflow dropped", mon_cnt - c0, 2);
    check("R4 count", frame_bits, 2);
    host_read(A_CLOSE); wait_idle();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_play_frame();
    t_cap_frame();
    t_timing();
    t_buffer();
    t_len_and_other();
    t_protocol();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule